// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial bus in front of a 512-byte memory array, which is held in internal registers. It samples SCL and SDA with the system clock and finds START and STOP conditions and clock edges. It decodes the slave byte, acknowledges bytes and carries out byte writes, page writes, current-address reads, sequential reads and random reads. SDA is open-drain: the block never drives a high level. It only raises an output enable that pulls the line low.

Memory writes pass through two gates. The first is a volatile write-enable bit. The second is a protect bit that locks the upper half of the array. Both bits sit in a small control register, which has its own slave byte. Write data collects in a 16-byte page buffer and reaches the array only on a STOP that ends a transaction cleanly. After each such write the device stays busy for a set number of clocks and refuses every slave byte. A master can therefore poll for the end of the write cycle by checking for an acknowledge.

Top module: `ee2w_slave`

## Requirements
- R1: After reset, and whenever no transaction is open, `sda_oe` is 0. A START condition is SDA falling while SCL is high, and it opens a transaction. A STOP condition is SDA rising while SCL is high, and it closes the transaction.
- R2: A slave byte whose bits [7:2] are 101000 selects the array. Its bit 1 becomes address bit 8, and bit 0 = 1 means read. Slave byte DEh writes the control register and DFh reads it. Any other slave byte is not acknowledged.
- R3: A byte write (array slave byte with bit 0 = 0, then the low address byte, then one data byte, then STOP) stores the data at the 9-bit address. A later read returns it.
- R4: In a page write, each data byte goes to the current address and then the low 4 address bits increment modulo 16. Bits 8:4 stay fixed, so a write that runs past the end of a 16-byte page wraps to the start of the same page.
- R5: Buffered data is committed only when the STOP follows a complete data byte and its acknowledge slot. A STOP in the middle of a byte, or a repeated START, throws away the whole write and does not start a busy period.
- R6: Bit 1 of a byte written to the control register loads the write-enable bit. While that bit is 0, array writes are acknowledged but leave the array unchanged and start no busy period.
- R7: Bit 4 of a control byte loads the protect bit, but only if write-enable was already 1 before that byte was committed. While protect is 1, writes to addresses with bit 8 = 1 are ignored and writes to the lower half are still accepted.
- R8: After a committed array write, every slave byte is left unacknowledged for WR_CYCLES clocks. After that, slave bytes are acknowledged again.
- R9: Each byte read returns the array byte at the address counter, and the counter then increments. It wraps from 511 to 0. A master NACK ends the read.
- R10: A random read is an address write followed by a repeated START and a read slave byte. If a STOP takes the place of that repeated START, only the address counter is set, and a later current-address read starts there.
- R11: A read of the control register returns write-enable in bit 1 and protect in bit 4, with all other bits 0.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wired bus |
| sda_oe | output | 1 | When 1, pulls SDA low |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except when the master forms a START or STOP. Each SCL level lasts several system clocks, so every edge is seen before the next one arrives. The assertions also assume that no master tries a START while the slave holds SDA low. The bench drives the bus through tasks that hold each quarter of a bit period for four clocks and move SDA in the low phase. It forms START and STOP only while the slave is released.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  localparam int EE_AW = 9;
  localparam logic [5:0] ARRAY_TAG = 6'b101000;
  localparam logic [6:0] CTRL_TAG  = 7'b1101111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_CDATA, ST_RDATA, ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/ee2w_line_sense.sv
module ee2w_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_p <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i; scl_p <= scl_q;
      sda_q <= sda_i; sda_p <= sda_q;
    end
  end

  assign scl_hi   = scl_q;
  assign sda_bit  = sda_q;
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
  parameter int AW     = 9,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [AW-PAGE_W-1:0]     base,
  input  logic [(1<<PAGE_W)*8-1:0] page_data,
  input  logic [(1<<PAGE_W)-1:0]   page_mask,
  input  logic [AW-1:0]            raddr,
  output logic [7:0]               rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGES = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int j = 0; j < PAGES; j++)
        if (page_mask[j]) mem[{base, PAGE_W'(j)}] <= page_data[j*8 +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ee2w_busy_timer.sv
module ee2w_busy_timer #(
  parameter int WR_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  // R8: the write cycle counts down one per clock until it ends
  p_busy_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave import ee2w_pkg::*; #(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW    = EE_AW;
  localparam int PAGES = 1 << PAGE_W;

  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + PAGE_W'(1))};
  endfunction

  function automatic logic locked(input logic prot, input logic [AW-1:0] a);
    return prot & a[AW-1];
  endfunction

  function automatic logic [7:0] ctrl_image(input logic prot, input logic we);
    return {3'b000, prot, 2'b00, we, 1'b0};
  endfunction

  logic scl_hi, sda_bit, scl_rise, scl_fall, start_ev, stop_ev;
  ee2w_line_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_bit(sda_bit), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ee_state_e             st;
  logic [3:0]            bitcnt;
  logic [7:0]            shreg, cbyte;
  logic [AW-1:0]         addr;
  logic [PAGES*8-1:0]    pbuf;
  logic [PAGES-1:0]      pmask;
  logic                  have_data, ctl_rd, mack, wel, bp, oe_q;
  logic [7:0]            rdata, tx_next;
  logic                  busy;

  // named events
  logic stop_ok, arr_commit, ctl_commit, byte_done, ev_dev_done, ev_data_done;
  assign stop_ok      = stop_ev && have_data && (bitcnt <= 4'd1);
  assign arr_commit   = stop_ok && (st == ST_WDATA) && wel && !locked(bp, addr);
  assign ctl_commit   = stop_ok && (st == ST_CDATA);
  assign byte_done    = scl_fall && (bitcnt == 4'd8) &&
                        (st == ST_DEV || st == ST_ADDR || st == ST_WDATA || st == ST_CDATA);
  assign ev_dev_done  = byte_done && (st == ST_DEV);
  assign ev_data_done = byte_done && (st == ST_WDATA);
  assign tx_next      = ctl_rd ? ctrl_image(bp, wel) : rdata;

  ee2w_store #(.AW(AW), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(arr_commit),
    .base(addr[AW-1:PAGE_W]), .page_data(pbuf), .page_mask(pmask),
    .raddr(addr), .rdata(rdata)
  );

  ee2w_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(arr_commit), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; cbyte <= '0; addr <= '0;
      pbuf <= '0; pmask <= '0; have_data <= 1'b0; ctl_rd <= 1'b0;
      mack <= 1'b0; wel <= 1'b0; bp <= 1'b0; oe_q <= 1'b0;
    end else if (start_ev) begin
      st <= ST_DEV; bitcnt <= '0; oe_q <= 1'b0;
      have_data <= 1'b0; pmask <= '0;
    end else if (stop_ev) begin
      st <= ST_IDLE; oe_q <= 1'b0; have_data <= 1'b0; pmask <= '0;
      if (ctl_commit) begin
        wel <= cbyte[1];
        if (wel) bp <= cbyte[4];
      end
    end else begin
      case (st)
        ST_DEV, ST_ADDR, ST_WDATA, ST_CDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= 4'd9;
            oe_q   <= 1'b1;
            case (st)
              ST_DEV: begin
                if (busy) begin
                  oe_q <= 1'b0; st <= ST_SKIP;
                end else if (shreg[7:2] == ARRAY_TAG) begin
                  addr[AW-1] <= shreg[1];
                  if (shreg[0]) begin st <= ST_RDATA; mack <= 1'b1; ctl_rd <= 1'b0; end
                  else st <= ST_ADDR;
                end else if (shreg[7:1] == CTRL_TAG) begin
                  if (shreg[0]) begin st <= ST_RDATA; mack <= 1'b1; ctl_rd <= 1'b1; end
                  else st <= ST_CDATA;
                end else begin
                  oe_q <= 1'b0; st <= ST_SKIP;
                end
              end
              ST_ADDR: begin
                addr[AW-2:0] <= shreg;
                st <= ST_WDATA;
              end
              ST_WDATA: begin
                pbuf[addr[PAGE_W-1:0]*8 +: 8] <= shreg;
                pmask[addr[PAGE_W-1:0]]      <= 1'b1;
                addr      <= page_step(addr);
                have_data <= 1'b1;
              end
              default: begin
                cbyte     <= shreg;
                have_data <= 1'b1;
              end
            endcase
          end else if (scl_fall && bitcnt == 4'd9) begin
            oe_q   <= 1'b0;
            bitcnt <= '0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (bitcnt == 4'd8) mack <= ~sda_bit;
            if (bitcnt < 4'd9)  bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt < 4'd8) begin
              oe_q <= ~shreg[3'd7 - bitcnt[2:0]];
            end else if (bitcnt == 4'd8) begin
              oe_q <= 1'b0;
            end else if (mack) begin
              shreg  <= tx_next;
              oe_q   <= ~tx_next[7];
              bitcnt <= '0;
              if (!ctl_rd) addr <= addr + AW'(1);
            end else begin
              oe_q <= 1'b0;
              st   <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  // R1: no pull-down outside an open transaction
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R4: a data byte never moves the address out of its page
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_done |=> $stable(addr[AW-1:PAGE_W]));

  // R6: a write cycle only begins with the enable latch set
  p_wr_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R7: a write cycle never begins for the locked half
  p_wr_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !($past(bp) && $past(addr[AW-1])));

  // R8: slave byte during the write cycle is not acknowledged
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dev_done && busy) |=> !sda_oe);

  // R12: the data line drive moves only in the clock low phase
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_hi);
endmodule

// File: tb/sim_ee2w_slave.sv
module sim_ee2w_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 4;
  localparam int WR    = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int mm [512];
  logic [8:0] m_addr = '0;
  logic m_wel = 1'b0, m_bp = 1'b0;
  logic [7:0] wbuf [16];

  always #(CLK_P/2) clk = ~clk;

  ee2w_slave #(.PAGE_W(4), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R12 monitor: drive changes only while SCL is low
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe) begin
      checks++;
      if (scl !== 1'b0) begin
        failures++;
        $display("FAIL R12 actual=%0h expected=0 (scl when oe moved)", scl);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic q(); repeat (Q) @(posedge clk); #2; endtask
  task automatic bit_out(input logic b); sda_m = b; q(); scl = 1; q(); q(); scl = 0; q(); endtask
  task automatic bit_in(output logic b); sda_m = 1; q(); scl = 1; q(); b = sda_bus; q(); scl = 0; q(); endtask
  task automatic do_start(); sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q(); endtask
  task automatic do_stop(); sda_m = 0; q(); scl = 1; q(); sda_m = 1; q(); endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv(output logic [7:0] b, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); b[i] = x; end
    bit_out(!give_ack);
  endtask

  task automatic wr_array(input logic [8:0] a, input int n, input string req, output bit done);
    logic ack;
    do_start();
    send({6'b101000, a[8], 1'b0}, ack); chk({req, " dev ack"}, ack, 1);
    send(a[7:0], ack);                  chk({req, " addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin send(wbuf[k], ack); chk({req, " data ack"}, ack, 1); end
    do_stop();
    done = m_wel && !(m_bp && a[8]);
    if (done)
      for (int k = 0; k < n; k++) mm[{a[8:4], 4'(a[3:0] + 4'(k))}] = int'(wbuf[k]);
    m_addr = {a[8:4], 4'(a[3:0] + 4'(n))};
  endtask

  task automatic rd_random(input logic [8:0] a, input int n, input string req);
    logic ack; logic [7:0] b;
    do_start();
    send({6'b101000, a[8], 1'b0}, ack); chk({req, " dev ack"}, ack, 1);
    send(a[7:0], ack);                  chk({req, " addr ack"}, ack, 1);
    do_start();
    send({6'b101000, a[8], 1'b1}, ack); chk({req, " rd ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(b, k != n - 1);
      chk({req, " data"}, int'(b), mm[9'(a + 9'(k))]);
    end
    do_stop();
    m_addr = 9'(a + 9'(n));
  endtask

  task automatic rd_current(input int n, input logic hi, input string req);
    logic ack; logic [7:0] b;
    m_addr[8] = hi;
    do_start();
    send({6'b101000, hi, 1'b1}, ack); chk({req, " rd ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(b, k != n - 1);
      chk({req, " data"}, int'(b), mm[m_addr]);
      m_addr = m_addr + 9'd1;
    end
    do_stop();
  endtask

  task automatic ctl_wr(input logic [7:0] d, input string req);
    logic ack; logic nw;
    do_start();
    send(8'hDE, ack); chk({req, " ctl dev ack"}, ack, 1);
    send(d, ack);     chk({req, " ctl data ack"}, ack, 1);
    do_stop();
    nw = d[1];
    if (m_wel) m_bp = d[4];
    m_wel = nw;
  endtask

  task automatic ctl_rd(input string req);
    logic ack; logic [7:0] b;
    do_start();
    send(8'hDF, ack); chk({req, " ctl rd ack"}, ack, 1);
    recv(b, 1'b0);
    do_stop();
    chk({req, " ctl image"}, int'(b), (int'(m_bp) << 4) | (int'(m_wel) << 1));
  endtask

  task automatic settle(); repeat (WR + 100) @(posedge clk); #2; endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit done; logic ack;
    for (int i = 0; i < 512; i++) mm[i] = 8'hFF;
    repeat (5) @(posedge clk); #2;
    chk("R1 reset oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk); #2;
    chk("R1 idle oe", int'(sda_oe), 0);

    ctl_rd("R11 reset");

    // R6: write with enable clear is ignored and starts no busy period
    wbuf[0] = 8'h3C;
    wr_array(9'h010, 1, "R6 locked", done);
    rd_random(9'h010, 1, "R6 unchanged");

    ctl_wr(8'h02, "R6 set wel");
    ctl_rd("R11 wel");

    // R3 / R8: byte write then acknowledge polling
    wbuf[0] = 8'h5A;
    wr_array(9'h010, 1, "R3 byte", done);
    do_start(); send(8'hA0, ack); do_stop();
    chk("R8 poll nack", int'(ack), 0);
    settle();
    rd_random(9'h010, 1, "R3 R10 readback");

    // R4: page write wraps inside the page
    for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'hA0 + k);
    wr_array(9'h1FC, 6, "R4 page", done);
    settle();
    rd_random(9'h1FE, 4, "R9 wrap");
    rd_current(1, 1'b0, "R9 current");
    rd_random(9'h1F0, 2, "R4 wrapped bytes");

    // R5: STOP mid byte aborts
    do_start(); send(8'hA0, ack); send(8'h20, ack); send(8'h11, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_stop();
    rd_random(9'h020, 1, "R5 midbyte abort");
    // R5: repeated START aborts
    do_start(); send(8'hA0, ack); send(8'h21, ack); send(8'h22, ack);
    do_start(); do_stop();
    rd_random(9'h021, 1, "R5 restart abort");

    // R10: set current address with STOP
    do_start(); send(8'hA0, ack); send(8'h10, ack); do_stop();
    m_addr = 9'h010;
    rd_current(1, 1'b0, "R10 set addr");

    // R7: protect upper half
    ctl_wr(8'h12, "R7 set bp");
    ctl_rd("R7 R11 image");
    wbuf[0] = 8'h77;
    wr_array(9'h1FC, 1, "R7 upper", done);
    rd_random(9'h1FC, 1, "R7 upper kept");
    wbuf[0] = 8'h33;
    wr_array(9'h030, 1, "R7 lower", done);
    settle();
    rd_random(9'h030, 1, "R7 lower written");

    // R7: protect changes only with enable already set
    ctl_wr(8'h10, "R7 clear wel");
    ctl_wr(8'h00, "R7 bp held");
    ctl_rd("R7 R11 final");
    wbuf[0] = 8'h44;
    wr_array(9'h040, 1, "R6 disabled", done);
    rd_random(9'h040, 1, "R6 disabled kept");

    // R2: foreign slave byte is refused
    do_start(); send(8'h90, ack); do_stop();
    chk("R2 foreign nack", int'(ack), 0);
    repeat (10) @(posedge clk); #2;
    chk("R1 end oe", int'(sda_oe), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule